// File: doc/BRIEF.md
# Memory Pattern Test Engine

This block is a self-test engine for a synchronous, word-wide memory with a fixed read latency. When started, it sweeps the whole address space four times, once for each data pattern. Each sweep has two passes. The write pass stores the pattern at every address in ascending order. The read pass then visits the same addresses in the same order. Read data is compared against the expected word, which the engine carries through a delay line matched to the memory's read latency.

The engine drives a plain memory port made of address, write enable and write data, and it accepts read data back. One sweep's read pass is followed at once by the next sweep's write pass, so the compares still in flight finish while the new writes have begun.

At the end the engine reports:
- whether the whole test passed;
- a saturating count of mismatched words;
- the address of the first mismatch seen.

Top module: `mem_pattern_bist`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `mem_we` are 0, and `err_count` and `fail_addr` are 0.
- R2: A `start` pulse seen while the engine is idle begins a run and clears `done`, `pass`, `err_count` and `fail_addr`. A `start` seen while `busy` is high is ignored: the run keeps its length and its result.
- R3: A run performs four sweeps in a fixed order: all-ones, all-zeros, alternating, pseudo-random. Each sweep writes addresses 0 to DEPTH-1 in ascending order, then reads them back in the same order. A run therefore issues exactly 4*DEPTH writes.
- R4: The all-ones sweep writes every bit as 1. The all-zeros sweep writes every bit as 0.
- R5: The alternating sweep writes an all-ones word at even addresses and an all-zeros word at odd addresses.
- R6: The pseudo-random sweep writes SEED at address 0. Each following address gets the next state of a right-shifting Galois LFSR, where next = s[0] ? (s >> 1) ^ POLY : s >> 1. The read pass regenerates the same sequence from SEED.
- R7: For a read issued in cycle t, `mem_rdata` is compared with the expected word in cycle t + RD_LAT. A fault-free memory with that latency yields zero mismatches.
- R8: Every compared word that differs from its expected value adds one to `err_count`. The count saturates at 2^ERR_W - 1.
- R9: `fail_addr` holds the address of the earliest mismatch in time order, and keeps it until the next accepted `start`. It is 0 when no mismatch occurred.
- R10: `done` rises 8*DEPTH + RD_LAT + 1 clock edges after the edge that accepts `start`. At the same time `pass` becomes 1 exactly when `err_count` is 0. `done` and the results then hold, with `busy` low, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after the read address |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; results valid |
| pass | output | 1 | No mismatch in the finished run |
| err_count | output | ERR_W | Saturating mismatch count |
| fail_addr | output | ADDR_W | Address of the first mismatch |

## Verification
The tail of each read pass overlaps the head of the next write pass. The last RD_LAT compares of one sweep therefore resolve in the same cycles as the first writes of the following sweep. The bench provokes this by planting a stuck bit at the highest address, so that a mismatch from the all-zeros sweep lands during the alternating sweep's opening writes. It judges the outcome on three things: the mismatch count and first-fail address, both predicted by replaying the fault model over all four patterns; and the write data of the new sweep, which a write monitor checks word by word.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  typedef enum logic [1:0] {
    PAT_ONES  = 2'd0,
    PAT_ZEROS = 2'd1,
    PAT_ALT   = 2'd2,
    PAT_RAND  = 2'd3
  } pat_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DRAIN = 2'd3
  } st_e;
endpackage

// File: rtl/mpb_sequencer.sv
module mpb_sequencer
  import mpb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output st_e               st,
  output pat_e              pat,
  output logic [ADDR_W-1:0] addr,
  output logic              launch,
  output logic              finish
);
  localparam int CW = $clog2(RD_LAT + 1) + 1;
  localparam logic [ADDR_W-1:0] LAST = '1;
  localparam logic [CW-1:0] DRAIN_END = CW'(RD_LAT);

  st_e st_q;
  pat_e pat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  assign st     = st_q;
  assign pat    = pat_q;
  assign addr   = addr_q;
  assign launch = (st_q == ST_IDLE) && start;
  assign finish = (st_q == ST_DRAIN) && (cnt_q == DRAIN_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      pat_q  <= PAT_ONES;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_WRITE;
            pat_q  <= PAT_ONES;
            addr_q <= '0;
          end
        end
        ST_WRITE: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == LAST) st_q <= ST_READ;
        end
        ST_READ: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == LAST) begin
            if (pat_q == PAT_RAND) begin
              st_q  <= ST_DRAIN;
              cnt_q <= '0;
            end else begin
              st_q  <= ST_WRITE;
              pat_q <= pat_e'(pat_q + 2'd1);
            end
          end
        end
        ST_DRAIN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == DRAIN_END) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: each pass walks addresses upward by one per cycle
  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_WRITE || st_q == ST_READ) && addr_q != LAST) |=>
      (addr_q == $past(addr_q) + 1'b1 && st_q == $past(st_q)));

  // R3: a finished read pass hands over to the next pattern's write pass
  p_pat_order_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_READ && addr_q == LAST && pat_q != PAT_RAND) |=>
      (st_q == ST_WRITE && pat_q == pat_e'($past(pat_q) + 2'd1) && addr_q == '0));

  // R3: a write pass is always followed by a read of the same pattern
  p_write_then_read_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WRITE && addr_q == LAST) |=>
      (st_q == ST_READ && $stable(pat_q)));
endmodule

// File: rtl/mpb_patgen.sv
module mpb_patgen
  import mpb_pkg::*;
#(
  parameter int              ADDR_W = 4,
  parameter int              DATA_W = 16,
  parameter logic [DATA_W-1:0] POLY = 16'hB400,
  parameter logic [DATA_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  pat_e              pat,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] lfsr_q;
  logic [DATA_W-1:0] rnd;
  logic [DATA_W-1:0] rnd_next;

  // Address 0 restarts the sequence, so both passes see the same words.
  assign rnd      = (addr == '0) ? SEED : lfsr_q;
  assign rnd_next = rnd[0] ? ((rnd >> 1) ^ POLY) : (rnd >> 1);

  always_ff @(posedge clk) begin
    if (rst)      lfsr_q <= SEED;
    else if (adv) lfsr_q <= rnd_next;
  end

  always_comb begin
    unique case (pat)
      PAT_ONES:  word = '1;
      PAT_ZEROS: word = '0;
      PAT_ALT:   word = addr[0] ? '0 : '1;
      default:   word = rnd;
    endcase
  end

  // R6: a nonzero seed never lets the register collapse to zero
  p_lfsr_live_r6: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
endmodule

// File: rtl/mpb_compare.sv
module mpb_compare #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              issue,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [ADDR_W-1:0] exp_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ERR_W-1:0]  err_count,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [RD_LAT-1:0] vld_q;
  logic [DATA_W-1:0] exp_q  [RD_LAT];
  logic [ADDR_W-1:0] adr_q  [RD_LAT];
  logic              any_q;
  logic              hit;

  always_ff @(posedge clk) begin
    if (rst || clear) vld_q[0] <= 1'b0;
    else              vld_q[0] <= issue;
    exp_q[0] <= exp_word;
    adr_q[0] <= exp_addr;
  end

  genvar g;
  generate
    for (g = 1; g < RD_LAT; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst || clear) vld_q[g] <= 1'b0;
        else              vld_q[g] <= vld_q[g-1];
        exp_q[g] <= exp_q[g-1];
        adr_q[g] <= adr_q[g-1];
      end
    end
  endgenerate

  assign hit = vld_q[RD_LAT-1] && (mem_rdata != exp_q[RD_LAT-1]);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      err_count <= '0;
      fail_addr <= '0;
      any_q     <= 1'b0;
    end else if (hit) begin
      if (err_count != ERR_MAX) err_count <= err_count + 1'b1;
      if (!any_q) begin
        fail_addr <= adr_q[RD_LAT-1];
        any_q     <= 1'b1;
      end
    end
  end

  // R8: the count never falls between clears
  p_err_monotone_r8: assert property (@(posedge clk) disable iff (rst)
    !clear |=> err_count >= $past(err_count));

  // R8: a saturated count stays put
  p_err_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (err_count == ERR_MAX && !clear) |=> err_count == ERR_MAX);

  // R9: once captured, the first failing address is frozen
  p_first_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (any_q && !clear) |=> $stable(fail_addr));
endmodule

// File: rtl/mem_pattern_bist.sv
module mem_pattern_bist
  import mpb_pkg::*;
#(
  parameter int                ADDR_W = 4,
  parameter int                DATA_W = 16,
  parameter int                RD_LAT = 2,
  parameter int                ERR_W  = 8,
  parameter logic [DATA_W-1:0] POLY   = 16'hB400,
  parameter logic [DATA_W-1:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ERR_W-1:0]  err_count,
  output logic [ADDR_W-1:0] fail_addr
);
  st_e               st;
  pat_e              pat;
  logic [ADDR_W-1:0] addr;
  logic              launch;
  logic              finish;
  logic [DATA_W-1:0] word;

  mpb_sequencer #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .st(st), .pat(pat), .addr(addr), .launch(launch), .finish(finish)
  );

  mpb_patgen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLY(POLY), .SEED(SEED)) u_gen (
    .clk(clk), .rst(rst),
    .adv(st == ST_WRITE || st == ST_READ),
    .pat(pat), .addr(addr), .word(word)
  );

  mpb_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT), .ERR_W(ERR_W)) u_cmp (
    .clk(clk), .rst(rst), .clear(launch),
    .issue(st == ST_READ), .exp_word(word), .exp_addr(addr),
    .mem_rdata(mem_rdata), .err_count(err_count), .fail_addr(fail_addr)
  );

  assign mem_addr  = addr;
  assign mem_we    = (st == ST_WRITE);
  assign mem_wdata = word;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst || launch) begin
      done <= 1'b0;
      pass <= 1'b0;
    end else if (finish) begin
      done <= 1'b1;
      pass <= (err_count == '0);
    end
  end

  // R2: an accepted start wipes the previous results
  p_launch_clear_r2: assert property (@(posedge clk) disable iff (rst)
    launch |=> (err_count == '0 && !done && !pass && busy));

  // R10: results stay until a new start is accepted
  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pass) && $stable(err_count)));

  // R10: done and busy never overlap
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/sim_mem_pattern_bist.sv
`timescale 1ns/1ps
module sim_mem_pattern_bist;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int LAT = 3;
  localparam int EW = 5;
  localparam int EMAX = (1 << EW) - 1;
  localparam logic [DW-1:0] POLY = 16'hB400;
  localparam logic [DW-1:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_we;
  logic [DW-1:0] mem_wdata;
  logic busy, done, pass;
  logic [EW-1:0] err_count;
  logic [AW-1:0] fail_addr;

  int n_chk = 0;
  int n_bad = 0;
  int wcount = 0;

  always #2.5 clk = ~clk;

  mem_pattern_bist #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT), .ERR_W(EW),
                     .POLY(POLY), .SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .start(start), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .pass(pass),
    .err_count(err_count), .fail_addr(fail_addr)
  );

  // fault model: stuck bits at one address or at all addresses
  logic          f_on = 1'b0;
  logic          f_all = 1'b0;
  logic          f_high = 1'b1;
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_mask = '0;

  function automatic logic [DW-1:0] apply_fault(logic [DW-1:0] w, logic [AW-1:0] a);
    if (f_on && (f_all || a == f_addr))
      return f_high ? (w | f_mask) : (w & ~f_mask);
    return w;
  endfunction

  function automatic logic [DW-1:0] exp_word(int p, int a);
    logic [DW-1:0] s;
    case (p)
      0: return '1;
      1: return '0;
      2: return (a % 2 == 0) ? '1 : '0;
      default: begin
        s = SEED;
        for (int k = 0; k < a; k++) s = s[0] ? ((s >> 1) ^ POLY) : (s >> 1);
        return s;
      end
    endcase
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rpipe [LAT];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= apply_fault(mem_wdata, mem_addr);
    rpipe[0] <= mem[mem_addr];
    for (int k = 1; k < LAT; k++) rpipe[k] <= rpipe[k-1];
  end
  assign mem_rdata = rpipe[LAT-1];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // write monitor: R3 order, R4/R5/R6 data
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      int p, a;
      string rq;
      p = (wcount % (4 * DEPTH)) / DEPTH;
      a = wcount % DEPTH;
      rq = (p < 2) ? "R4" : (p == 2) ? "R5" : "R6";
      check(mem_addr == AW'(a), "R3", "write address", mem_addr, a);
      check(mem_wdata == exp_word(p, a), rq, "write data", mem_wdata, exp_word(p, a));
      wcount <= wcount + 1;
    end
  end

  task automatic predict(output int cnt, output int first);
    logic [DW-1:0] e;
    bit seen;
    cnt = 0; first = 0; seen = 0;
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < DEPTH; a++) begin
        e = exp_word(p, a);
        if (apply_fault(e, AW'(a)) != e) begin
          cnt++;
          if (!seen) begin first = a; seen = 1; end
        end
      end
    if (cnt > EMAX) cnt = EMAX;
  endtask

  task automatic run(input bit poke_mid, input string tag);
    int n, w0, ecnt, efirst;
    predict(ecnt, efirst);
    @(negedge clk);
    w0 = wcount;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check(busy && !done && err_count == 0, "R2", {tag, " launch"}, {busy, done}, 2'b10);
    while (!done && n < 2000) begin
      if (poke_mid && n == 40) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    check(n < 2000, "R10", {tag, " watchdog"}, n, 8 * DEPTH + LAT + 2);
    check(n == 8 * DEPTH + LAT + 2, poke_mid ? "R2" : "R10", {tag, " run length"},
          n, 8 * DEPTH + LAT + 2);
    check(wcount - w0 == 4 * DEPTH, "R3", {tag, " write count"}, wcount - w0, 4 * DEPTH);
    check(err_count == EW'(ecnt), (ecnt == EMAX) ? "R8" : "R7", {tag, " mismatches"},
          err_count, ecnt);
    check(fail_addr == AW'(efirst), "R9", {tag, " first fail"}, fail_addr, efirst);
    check(pass == (ecnt == 0), "R10", {tag, " pass"}, pass, ecnt == 0);
    check(!busy, "R10", {tag, " idle at done"}, busy, 0);
    repeat (10) @(negedge clk);
    check(done && err_count == EW'(ecnt) && fail_addr == AW'(efirst), "R10",
          {tag, " hold"}, {done, err_count}, {1'b1, EW'(ecnt)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !pass && !mem_we, "R1", "reset flags",
          {busy, done, pass, mem_we}, 0);
    check(err_count == 0 && fail_addr == 0, "R1", "reset results",
          {err_count, fail_addr}, 0);

    run(1'b0, "clean");                          // R7: zero mismatches at matched latency

    f_on = 1; f_all = 0; f_high = 1; f_addr = AW'(DEPTH - 1); f_mask = 16'h0010;
    run(1'b0, "top-addr stuck1");                // overlap of tail compares and next writes

    f_on = 1; f_all = 0; f_high = 0; f_addr = 4'd5; f_mask = 16'h0008;
    run(1'b0, "addr5 stuck0");                   // R9: fails first in all-ones sweep

    f_on = 1; f_all = 1; f_high = 1; f_mask = 16'hFFFF;
    run(1'b0, "all stuck1");                     // R8: saturates

    f_on = 0;
    run(1'b1, "clean with start mid-run");       // R2: mid-run start ignored, results cleared

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule